// File: doc/BRIEF.md
# Multi-Channel PWM Generator with Shared Timebases

This block produces a set of pulse-width-modulated outputs from three shared timebases. Each timebase chains a 16-bit prescaler and an 8-bit cycle timer. It counts ticks from either a fast or a slow tick-enable input, and a per-timebase source bit picks which one. Both tick inputs are qualifiers on the single system clock, so the whole block runs in one clock domain. The output period of a timebase is (P + 1) × (T + 1) source ticks, where P is the prescaler value and T is the cycle-timer value.

Every channel routes itself to one timebase through a 2-bit field. It compares the timebase's cycle count against its own 8-bit duty value, which gives an active pulse of duty/(T + 1) of the period. It can invert the result, hold it idle through a gate bit, or act as an open-drain pad driver. Software programs all of this through a byte-wide synchronous write/read port. Prescaler values, cycle-timer values and duty values are held in shadow copies. A new value only takes effect at the next period boundary of its timebase, so a write never produces a runt pulse. The build supports one to eight channels.

Top module: `pwm_multi_ch`

## Requirements
- R1: After reset every `pwm_out` bit is 0, every `pwm_oe` bit is 1, and the control byte at address 0x00 reads 0.
- R2: A timebase period lasts (P + 1) × (T + 1) ticks of its source. Timebase p keeps P as a low byte at 0x10+4p and a high byte at 0x11+4p, and keeps T at 0x12+4p. All three read back as written.
- R3: With polarity clear, a channel is high while its timebase count is below its duty byte (address 0x20+channel). Duty 0 keeps it low for the whole period. A duty above T keeps it high for the whole period.
- R4: Bit p of the source byte at 0x01 selects the source for timebase p. A value of 1 counts `fast_tick` and 0 counts `slow_tick`.
- R5: The timebase select of channel c is the 2-bit field at bit (c mod 4)×2 of the byte at 0x08 + c/4. Values 0 to 2 pick that timebase. Value 3 keeps the channel at its inactive level.
- R6: Bit c of the gate byte at 0x02 holds channel c at its inactive level. The byte resets to all ones, so every channel starts gated.
- R7: Bit c of the polarity byte at 0x03 inverts channel c, which gives an active-low pulse.
- R8: When bit c of the open-drain byte at 0x04 is set, `pwm_oe[c]` is 1 exactly when `pwm_out[c]` is 0. When that bit is clear, `pwm_oe[c]` stays 1.
- R9: Address 0x13 is the high byte of cycle timer 0. It ignores writes and always reads 0.
- R10: While bit 0 of the control byte is clear, no timebase advances and every channel sits at its inactive level. When the bit is set, every timebase restarts from count 0.
- R11: A duty, prescaler or cycle-timer value written during a running period takes effect at the next period boundary of the timebase involved.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fast_tick | input | 1 | Tick enable of the fast source |
| slow_tick | input | 1 | Tick enable of the slow source |
| wr_en | input | 1 | Register write strobe |
| addr | input | 8 | Register address for writes and reads |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for the address presented one clock earlier |
| pwm_out | output | NUM_CH | Channel output levels |
| pwm_oe | output | NUM_CH | Channel pad drive enables |

## Verification
Read data is due one clock after the address is presented, so the bench sets the address just after one falling edge and samples `rdata` at the next. A register write lands at the rising edge after the strobe. The waveform it changes only follows at the next period boundary, or at once when counting is stopped. For this reason every waveform check first restarts the timebases, then waits one complete period so that a slow source's tick phase has settled. It then counts high samples at falling edges over a whole number of periods, which gives an exact total whatever the phase. The mid-period duty check starts at an observed rising edge and counts the rest of that period and all of the next one separately.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
  localparam int NUM_PRS = 3;
  localparam int CPRS_W  = 16;
  localparam int CTR_W   = 8;
  localparam int DUTY_W  = 8;
  localparam int ADDR_W  = 8;
  localparam int DATA_W  = 8;
  localparam int SEL_W   = 2;

  localparam logic [ADDR_W-1:0] A_CTRL   = 8'h00;
  localparam logic [ADDR_W-1:0] A_SRC    = 8'h01;
  localparam logic [ADDR_W-1:0] A_GATE   = 8'h02;
  localparam logic [ADDR_W-1:0] A_POL    = 8'h03;
  localparam logic [ADDR_W-1:0] A_OD     = 8'h04;
  localparam logic [ADDR_W-1:0] A_CHSEL  = 8'h08;
  localparam logic [ADDR_W-1:0] A_PRS    = 8'h10;
  localparam logic [ADDR_W-1:0] A_T0HI   = 8'h13;
  localparam logic [ADDR_W-1:0] A_DUTY   = 8'h20;

  typedef struct packed {
    logic [CPRS_W-1:0] cprs;
    logic [CTR_W-1:0]  ctr;
  } prs_cfg_t;

  // Address of byte k (0 low, 1 high, 2 cycle timer) of timebase p
  function automatic logic [ADDR_W-1:0] prs_addr(input int p, input int k);
    return A_PRS + ADDR_W'(4 * p + k);
  endfunction

  // Bit offset of a channel's select field inside its shared byte
  function automatic int sel_shift(input int ch);
    return (ch % 4) * SEL_W;
  endfunction

  function automatic logic sel_valid(input logic [SEL_W-1:0] s);
    return s < SEL_W'(NUM_PRS);
  endfunction

  function automatic logic duty_active(input logic [CTR_W-1:0] cnt,
                                       input logic [DUTY_W-1:0] duty);
    return cnt < duty;
  endfunction
endpackage

// File: rtl/pwm_regs.sv
module pwm_regs
  import pwm_pkg::*;
#(
  parameter int NUM_CH = 8
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             wr_en,
  input  logic [ADDR_W-1:0]                addr,
  input  logic [DATA_W-1:0]                wdata,
  output logic [DATA_W-1:0]                rdata,
  output logic                             run,
  output logic [NUM_PRS-1:0]               src_fast,
  output logic [NUM_CH-1:0]                gate,
  output logic [NUM_CH-1:0]                pol,
  output logic [NUM_CH-1:0]                od,
  output logic [NUM_CH-1:0][SEL_W-1:0]     chsel,
  output prs_cfg_t [NUM_PRS-1:0]           prs_cfg,
  output logic [NUM_CH-1:0][DUTY_W-1:0]    duty
);
  localparam int SEL_BYTES = (NUM_CH + 3) / 4;

  logic                          run_q;
  logic [NUM_PRS-1:0]            src_q;
  logic [NUM_CH-1:0]             gate_q, pol_q, od_q;
  logic [NUM_CH-1:0][SEL_W-1:0]  chsel_q;
  logic [NUM_PRS-1:0][CPRS_W-1:0] cprs_q;
  logic [NUM_PRS-1:0][CTR_W-1:0] ctr_q;
  logic [NUM_CH-1:0][DUTY_W-1:0] duty_q;
  logic [DATA_W-1:0]             rd_mux;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q   <= 1'b0;
      src_q   <= '0;
      gate_q  <= '1;
      pol_q   <= '0;
      od_q    <= '0;
      chsel_q <= '0;
      cprs_q  <= '0;
      ctr_q   <= '0;
      duty_q  <= '0;
    end else if (wr_en) begin
      case (addr)
        A_CTRL:  run_q  <= wdata[0];
        A_SRC:   src_q  <= wdata[NUM_PRS-1:0];
        A_GATE:  gate_q <= wdata[NUM_CH-1:0];
        A_POL:   pol_q  <= wdata[NUM_CH-1:0];
        A_OD:    od_q   <= wdata[NUM_CH-1:0];
        default: ;
      endcase
      for (int p = 0; p < NUM_PRS; p++) begin
        if (addr == prs_addr(p, 0)) cprs_q[p][7:0]  <= wdata;
        if (addr == prs_addr(p, 1)) cprs_q[p][15:8] <= wdata;
        if (addr == prs_addr(p, 2)) ctr_q[p]        <= wdata;
      end
      for (int c = 0; c < NUM_CH; c++) begin
        if (addr == A_DUTY + ADDR_W'(c)) duty_q[c] <= wdata;
        if (addr == A_CHSEL + ADDR_W'(c / 4))
          chsel_q[c] <= wdata[sel_shift(c) +: SEL_W];
      end
    end
  end

  always_comb begin
    rd_mux = '0;
    case (addr)
      A_CTRL:  rd_mux[0]            = run_q;
      A_SRC:   rd_mux[NUM_PRS-1:0]  = src_q;
      A_GATE:  rd_mux[NUM_CH-1:0]   = gate_q;
      A_POL:   rd_mux[NUM_CH-1:0]   = pol_q;
      A_OD:    rd_mux[NUM_CH-1:0]   = od_q;
      default: ;
    endcase
    for (int p = 0; p < NUM_PRS; p++) begin
      if (addr == prs_addr(p, 0)) rd_mux = cprs_q[p][7:0];
      if (addr == prs_addr(p, 1)) rd_mux = cprs_q[p][15:8];
      if (addr == prs_addr(p, 2)) rd_mux = ctr_q[p];
    end
    for (int b = 0; b < SEL_BYTES; b++) begin
      if (addr == A_CHSEL + ADDR_W'(b)) begin
        for (int c = b * 4; c < NUM_CH && c < b * 4 + 4; c++)
          rd_mux[sel_shift(c) +: SEL_W] = chsel_q[c];
      end
    end
    for (int c = 0; c < NUM_CH; c++) begin
      if (addr == A_DUTY + ADDR_W'(c)) rd_mux = duty_q[c];
    end
    if (addr == A_T0HI) rd_mux = '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) rdata <= '0;
    else        rdata <= rd_mux;
  end

  assign run      = run_q;
  assign src_fast = src_q;
  assign gate     = gate_q;
  assign pol      = pol_q;
  assign od       = od_q;
  assign chsel    = chsel_q;
  assign duty     = duty_q;

  for (genvar p = 0; p < NUM_PRS; p++) begin : g_cfg
    assign prs_cfg[p].cprs = cprs_q[p];
    assign prs_cfg[p].ctr  = ctr_q[p];
  end

  AST_T0HI_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    $past(addr) == A_T0HI |-> rdata == '0); // R9
  AST_GATE_RESET_SET: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> gate == '1); // R6
endmodule

// File: rtl/pwm_timebase.sv
module pwm_timebase
  import pwm_pkg::*;
#(
  parameter int PRE_W = CPRS_W,
  parameter int CYC_W = CTR_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             tick,
  input  logic [PRE_W-1:0] cprs_reg,
  input  logic [CYC_W-1:0] ctr_reg,
  output logic [CYC_W-1:0] cnt_o,
  output logic             load_o
);
  logic [PRE_W-1:0] pre_q, cprs_a;
  logic [CYC_W-1:0] cyc_q, ctr_a;
  logic             step, pre_wrap, period_end;

  assign step       = run & tick;
  assign pre_wrap   = step && (pre_q == cprs_a);
  assign period_end = pre_wrap && (cyc_q == ctr_a);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pre_q  <= '0;
      cyc_q  <= '0;
      cprs_a <= '0;
      ctr_a  <= '0;
    end else if (!run) begin
      pre_q  <= '0;
      cyc_q  <= '0;
      cprs_a <= cprs_reg;
      ctr_a  <= ctr_reg;
    end else if (step) begin
      if (pre_wrap) begin
        pre_q <= '0;
        if (period_end) begin
          cyc_q  <= '0;
          cprs_a <= cprs_reg;
          ctr_a  <= ctr_reg;
        end else begin
          cyc_q <= cyc_q + 1'b1;
        end
      end else begin
        pre_q <= pre_q + 1'b1;
      end
    end
  end

  assign cnt_o  = cyc_q;
  assign load_o = period_end | ~run;

  AST_CYC_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_q <= ctr_a); // R2
  AST_PRE_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    pre_q <= cprs_a); // R2
  AST_WRAP_TO_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    period_end |=> cyc_q == '0 && pre_q == '0); // R2
  AST_SHADOW_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    run && !period_end |=> $stable(ctr_a) && $stable(cprs_a)); // R11
  AST_IDLE_NO_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> cyc_q == '0); // R10
endmodule

// File: rtl/pwm_channel.sv
module pwm_channel
  import pwm_pkg::*;
(
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             run,
  input  logic                             gate,
  input  logic                             pol,
  input  logic                             od,
  input  logic [SEL_W-1:0]                 sel,
  input  logic [DUTY_W-1:0]                duty_reg,
  input  logic [NUM_PRS-1:0][CTR_W-1:0]    cnt_all,
  input  logic [NUM_PRS-1:0]               load_all,
  output logic                             pwm_o,
  output logic                             oe_o
);
  logic [DUTY_W-1:0] duty_sh;
  logic [CTR_W-1:0]  cur_cnt;
  logic              load_sel, sel_ok, active, level;

  assign sel_ok = sel_valid(sel);

  always_comb begin
    cur_cnt  = '0;
    load_sel = 1'b1;
    for (int p = 0; p < NUM_PRS; p++) begin
      if (sel == SEL_W'(p)) begin
        cur_cnt  = cnt_all[p];
        load_sel = load_all[p];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)        duty_sh <= '0;
    else if (load_sel) duty_sh <= duty_reg;
  end

  assign active = run & ~gate & sel_ok & duty_active(cur_cnt, duty_sh);
  assign level  = active ^ pol;
  assign pwm_o  = level;
  assign oe_o   = od ? ~level : 1'b1;

  AST_OD_RELEASE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    od && pwm_o |-> !oe_o); // R8
  AST_PUSH_PULL_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
    !od |-> oe_o); // R8
  AST_GATED_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    gate |-> pwm_o == pol); // R6
  AST_ZERO_DUTY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    duty_sh == '0 |-> pwm_o == pol); // R3
  AST_NO_SEL_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_ok |-> pwm_o == pol); // R5
  AST_DUTY_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    sel_ok && !load_sel |=> $stable(duty_sh)); // R11
endmodule

// File: rtl/pwm_multi_ch.sv
module pwm_multi_ch
  import pwm_pkg::*;
#(
  parameter int NUM_CH = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fast_tick,
  input  logic              slow_tick,
  input  logic              wr_en,
  input  logic [7:0]        addr,
  input  logic [7:0]        wdata,
  output logic [7:0]        rdata,
  output logic [NUM_CH-1:0] pwm_out,
  output logic [NUM_CH-1:0] pwm_oe
);
  logic                          run;
  logic [NUM_PRS-1:0]            src_fast;
  logic [NUM_CH-1:0]             gate, pol, od;
  logic [NUM_CH-1:0][SEL_W-1:0]  chsel;
  prs_cfg_t [NUM_PRS-1:0]        prs_cfg;
  logic [NUM_CH-1:0][DUTY_W-1:0] duty;
  logic [NUM_PRS-1:0][CTR_W-1:0] cnt_all;
  logic [NUM_PRS-1:0]            load_all;

  pwm_regs #(.NUM_CH(NUM_CH)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .addr     (addr),
    .wdata    (wdata),
    .rdata    (rdata),
    .run      (run),
    .src_fast (src_fast),
    .gate     (gate),
    .pol      (pol),
    .od       (od),
    .chsel    (chsel),
    .prs_cfg  (prs_cfg),
    .duty     (duty)
  );

  for (genvar p = 0; p < NUM_PRS; p++) begin : g_tb
    logic tick_p;
    assign tick_p = src_fast[p] ? fast_tick : slow_tick;
    pwm_timebase #(.PRE_W(CPRS_W), .CYC_W(CTR_W)) u_timebase (
      .clk      (clk),
      .rst_n    (rst_n),
      .run      (run),
      .tick     (tick_p),
      .cprs_reg (prs_cfg[p].cprs),
      .ctr_reg  (prs_cfg[p].ctr),
      .cnt_o    (cnt_all[p]),
      .load_o   (load_all[p])
    );
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    pwm_channel u_channel (
      .clk      (clk),
      .rst_n    (rst_n),
      .run      (run),
      .gate     (gate[c]),
      .pol      (pol[c]),
      .od       (od[c]),
      .sel      (chsel[c]),
      .duty_reg (duty[c]),
      .cnt_all  (cnt_all),
      .load_all (load_all),
      .pwm_o    (pwm_out[c]),
      .oe_o     (pwm_oe[c])
    );
  end

  AST_STOPPED_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> pwm_out == pol); // R10
  AST_RESET_OUTPUTS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> pwm_out == '0 && pwm_oe == '1); // R1
endmodule

// File: tb/pwm_multi_ch_tb.sv
`timescale 1ns/1ps
module pwm_multi_ch_tb;
  localparam int NCH = 8;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           fast_tick = 1'b1;
  logic           slow_tick = 1'b0;
  logic           wr_en = 1'b0;
  logic [7:0]     addr = '0;
  logic [7:0]     wdata = '0;
  logic [7:0]     rdata;
  logic [NCH-1:0] pwm_out, pwm_oe;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  int sdiv = 0;

  logic [7:0] gate_m = 8'hFF, pol_m = 8'h00, od_m = 8'h00, src_m = 8'h00;
  logic [7:0] sel_m [2];

  always #2.5 clk = ~clk;

  // slow source: one tick every four clocks
  always @(negedge clk) begin
    sdiv <= (sdiv + 1) % 4;
    slow_tick <= (sdiv == 3);
  end

  pwm_multi_ch #(.NUM_CH(NCH)) u_dut (
    .clk(clk), .rst_n(rst_n), .fast_tick(fast_tick), .slow_tick(slow_tick),
    .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata),
    .pwm_out(pwm_out), .pwm_oe(pwm_oe)
  );

  typedef struct packed {
    logic [3:0]  ch;
    logic [1:0]  sel;
    logic        fast;
    logic        pol;
    logic [15:0] cprs;
    logic [7:0]  ctr;
    logic [7:0]  duty;
    logic [15:0] period;
    logic [15:0] hi;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VECS [NV] = '{
    '{4'd0, 2'd0, 1'b1, 1'b0, 16'h0000, 8'd3, 8'd2, 16'd4,   16'd2},   // R3 basic
    '{4'd1, 2'd1, 1'b1, 1'b0, 16'h0001, 8'd4, 8'd1, 16'd10,  16'd2},   // R2 prescale by 2
    '{4'd2, 2'd2, 1'b0, 1'b0, 16'h0000, 8'd3, 8'd3, 16'd16,  16'd12},  // R4 slow source
    '{4'd3, 2'd0, 1'b1, 1'b1, 16'h0000, 8'd3, 8'd1, 16'd4,   16'd3},   // R7 inverted
    '{4'd4, 2'd1, 1'b1, 1'b0, 16'h0001, 8'd4, 8'd0, 16'd10,  16'd0},   // R3 duty zero
    '{4'd5, 2'd2, 1'b1, 1'b0, 16'h0002, 8'd1, 8'd5, 16'd6,   16'd6},   // R3 duty above T
    '{4'd6, 2'd0, 1'b1, 1'b0, 16'h0100, 8'd1, 8'd1, 16'd514, 16'd257}, // R2 high byte
    '{4'd7, 2'd3, 1'b1, 1'b0, 16'h0000, 8'd3, 8'd2, 16'd4,   16'd0}    // R5 select 3
  };

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    addr = a;
    @(negedge clk);
    d = rdata;
  endtask

  task automatic measure(input int ch, input int n, output int hi, output int oeh);
    hi = 0; oeh = 0;
    repeat (n) begin
      @(negedge clk);
      hi  += int'(pwm_out[ch]);
      oeh += int'(pwm_oe[ch]);
    end
  endtask

  task automatic apply(input vec_t v);
    int ch = int'(v.ch);
    int sel = int'(v.sel);
    wr(8'h00, 8'h00);
    if (sel < 3) begin
      wr(8'h10 + 8'(4 * sel), v.cprs[7:0]);
      wr(8'h11 + 8'(4 * sel), v.cprs[15:8]);
      wr(8'h12 + 8'(4 * sel), v.ctr);
      src_m[sel] = v.fast;
      wr(8'h01, src_m);
    end
    sel_m[ch / 4][(ch % 4) * 2 +: 2] = v.sel;
    wr(8'h08 + 8'(ch / 4), sel_m[ch / 4]);
    pol_m[ch] = v.pol;
    wr(8'h03, pol_m);
    wr(8'h20 + 8'(ch), v.duty);
    gate_m[ch] = 1'b0;
    wr(8'h02, gate_m);
    wr(8'h00, 8'h01);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    int hi, oeh, prev;
    sel_m[0] = '0; sel_m[1] = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // reset state
    chk("R1 pwm_out after reset", int'(pwm_out), 0);
    chk("R1 pwm_oe after reset", int'(pwm_oe), 255);
    rd(8'h00, d); chk("R1 control byte after reset", int'(d), 0);
    rd(8'h02, d); chk("R6 gate byte after reset", int'(d), 255);

    // timer 0 high byte ignores writes
    wr(8'h13, 8'hFF);
    rd(8'h13, d); chk("R9 timer0 high byte reads zero", int'(d), 0);

    // vector table walk
    for (int i = 0; i < NV; i++) begin
      apply(VECS[i]);
      measure(int'(VECS[i].ch), int'(VECS[i].period), hi, oeh); // settle one period
      measure(int'(VECS[i].ch), 3 * int'(VECS[i].period), hi, oeh);
      chk($sformatf("R2 R3 R4 R5 R7 vector %0d high count", i), hi, 3 * int'(VECS[i].hi));
    end

    rd(8'h11, d); chk("R2 prescaler 0 high byte readback", int'(d), 1);

    // open drain on channel 1: period 10, high 2
    od_m[1] = 1'b1;
    wr(8'h04, od_m);
    measure(1, 30, hi, oeh);
    chk("R8 open-drain output high count", hi, 6);
    chk("R8 open-drain enable count", oeh, 24);

    // gating channel 1
    gate_m[1] = 1'b1;
    wr(8'h02, gate_m);
    measure(1, 30, hi, oeh);
    chk("R6 gated channel high count", hi, 0);

    // mid-period duty change on channel 5 (timebase 2, fast, P 0, T 15)
    wr(8'h00, 8'h00);
    wr(8'h18, 8'h00);
    wr(8'h19, 8'h00);
    wr(8'h1A, 8'd15);
    src_m[2] = 1'b1;
    wr(8'h01, src_m);
    wr(8'h25, 8'd8);
    wr(8'h00, 8'h01);
    measure(5, 16, hi, oeh);
    prev = int'(pwm_out[5]);
    forever begin
      @(negedge clk);
      if (pwm_out[5] && prev == 0) break;
      prev = int'(pwm_out[5]);
    end
    hi = 1;
    addr = 8'h25; wdata = 8'd2; wr_en = 1'b1;
    @(negedge clk);
    hi += int'(pwm_out[5]);
    wr_en = 1'b0;
    repeat (14) begin
      @(negedge clk);
      hi += int'(pwm_out[5]);
    end
    chk("R11 current period keeps old duty", hi, 8);
    measure(5, 16, hi, oeh);
    chk("R11 next period uses new duty", hi, 2);

    // stop counting: channel 5 goes idle
    wr(8'h00, 8'h00);
    measure(5, 20, hi, oeh);
    chk("R10 stopped channel high count", hi, 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule